// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Timed Refresh

This block sits between a synchronous request port and a 128K x 16 DRAM with extended data output and page mode. Each request carries a 17-bit word address, 16 bits of write data, two byte enables and a read/write flag. The controller turns it into the strobe sequence the memory needs on a multiplexed 9-bit address bus: one row strobe, two column strobes (one per byte lane), a write enable and an output enable. The row stays open after an access, so that later requests to the same row need only a column strobe. Row address strobe timing, column strobe width and precharge are all counted in system clock cycles set by parameters.

A refresh timer raises a request at a parameter-set interval. Refresh uses a column-before-row sequence, so no row address is driven. A pending refresh closes the open page once the access in flight has finished, and it keeps the request port stalled until it is done. After reset the controller keeps every strobe inactive and runs a parameter-set number of refresh cycles (8 by default) before it takes its first request.

The request port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold every request field steady while `req_valid` is high and `req_ready` is low. `req_ready` falls for as long as an access is in progress or a refresh is pending or running. Read data comes back in request order as a one-cycle `rsp_valid` pulse. That return path has no back-pressure, so the host must accept it in the cycle it appears.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The word address is split with bits [16:9] as the row and bits [8:0] as the column. The row is driven on `dram_addr[7:0]` with `dram_addr[8]` = 0 when `dram_ras_n` falls. The column is driven on `dram_addr[8:0]` when a column strobe falls.
- R2: A read pulls both column strobes low with `dram_oe_n` low and `dram_we_n` high. It returns the addressed word on `rsp_rdata` with a one-cycle `rsp_valid` pulse. Responses come back in the order the reads were accepted.
- R3: A write pulls `dram_we_n` low, raises `dram_dq_oe` and drives `req_wdata` on `dram_dq_out`. Only the column strobes whose byte enables are set go low: `req_be[0]` drives `dram_cas_n[0]` (bits 7:0) and `req_be[1]` drives `dram_cas_n[1]` (bits 15:8). A write with both enables clear changes no memory byte.
- R4: While a row is open, a request to the same row is served by a column strobe alone, with no new row strobe, and the column access falls in the open row.
- R5: `dram_ras_n` stays high for at least T_RP cycles before every fall. A request to a different row closes the open page first.
- R6: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while an access is in flight. Every accepted request is carried out exactly once.
- R7: A refresh pulls both column strobes low at least one cycle before `dram_ras_n` falls. Refreshes recur at most REF_INTERVAL cycles apart, plus the time to finish one access.
- R8: While a refresh is pending or its strobe sequence is running, `req_ready` is low.
- R9: During reset and after it, every strobe is inactive. Exactly INIT_REFRESH refresh cycles run before `req_ready` first rises.
- R10: Outside a refresh, a column strobe is low only while `dram_ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address (row in [16:9], column in [8:0]) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes, bit 0 = low byte, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | High while `dram_dq_out` should drive the data pins |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
The assertions check the strobe rules on every cycle: the precharge width before each row strobe fall, column strobes never active without a row outside refresh, the column-first order of refresh, that a pending refresh blocks `req_ready`, and that each response follows a completed read strobe. Only the bench's scenarios can show the rest. That covers correct data through the address split, byte-lane masking (including a write with no lanes enabled), page hits that skip the row strobe, the count of start-up refreshes and the spacing of periodic refreshes under traffic. The bench does this with a behavioural memory and a scoreboard.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_OPEN,
    ST_COL_ACCESS,
    ST_PRECHARGE,
    ST_REFRESH
  } edo_state_e;
endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int W = $clog2(INTERVAL + 1);

  logic [W-1:0] cnt;
  logic         tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= W'(INTERVAL - 1);
      pend <= 1'b0;
    end else begin
      cnt  <= tick ? W'(INTERVAL - 1) : cnt - 1'b1;
      pend <= (pend & ~ack) | tick;
    end
  end

  // R7: an expiring interval always leaves a refresh pending
  p_tick_sets_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend);
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_W = 8,
  parameter int COL_W = 9
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   col_sel,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       bus
);
  logic [COL_W-1:0] row_ext;

  assign row = addr[ROW_W+COL_W-1:COL_W];

  always_comb begin
    row_ext = '0;
    row_ext[ROW_W-1:0] = row;
    bus = col_sel ? addr[COL_W-1:0] : row_ext;
  end
endmodule

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             same_row
);
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (!rst_n)    open_row <= '0;
    else if (load) open_row <= load_row;
  end

  assign same_row = (probe_row == open_row);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 9,
  parameter int LANES        = 2,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int T_CSR        = 1,
  parameter int T_RAS_REF    = 4,
  parameter int REF_INTERVAL = 780,
  parameter int INIT_REFRESH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [8*LANES-1:0]       req_wdata,
  input  logic [LANES-1:0]         req_be,
  output logic                     rsp_valid,
  output logic [8*LANES-1:0]       rsp_rdata,
  output logic [COL_W-1:0]         dram_addr,
  output logic                     dram_ras_n,
  output logic [LANES-1:0]         dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [8*LANES-1:0]       dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [8*LANES-1:0]       dram_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int DATA_W = 8 * LANES;
  localparam int CNT_W  = $clog2(T_RCD + T_CAS + T_RP + T_CSR + T_RAS_REF + 2);
  localparam int INIT_W = $clog2(INIT_REFRESH + 1);

  edo_state_e         st;
  logic [CNT_W-1:0]   cnt;
  logic [INIT_W-1:0]  init_left;
  logic               have_req;
  logic               ref_phase;
  logic               q_wr;
  logic [ADDR_W-1:0]  q_addr;
  logic [DATA_W-1:0]  q_data;
  logic [LANES-1:0]   q_be;
  logic               ref_pend;
  logic               ref_ack;
  logic               go_ref;
  logic               accept;
  logic               same_row;
  logic               col_sel;
  logic               row_load;
  logic [ROW_W-1:0]   q_row;
  logic [COL_W-1:0]   mux_bus;

  assign go_ref    = ref_pend || (init_left != '0);
  assign req_ready = (st == ST_IDLE || st == ST_ROW_OPEN) && !have_req && !go_ref;
  assign accept    = req_valid && req_ready;
  assign ref_ack   = (st == ST_IDLE) && !have_req && go_ref;
  assign col_sel   = (st == ST_ROW_OPEN);
  assign row_load  = (st == ST_IDLE) && have_req;

  edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
  );

  edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .addr(q_addr), .col_sel(col_sel), .row(q_row), .bus(mux_bus)
  );

  edo_page_tracker #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load(row_load), .load_row(q_row),
    .probe_row(req_addr[ADDR_W-1:COL_W]), .same_row(same_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_PRECHARGE;
      cnt         <= CNT_W'(T_RP - 1);
      init_left   <= INIT_W'(INIT_REFRESH);
      have_req    <= 1'b0;
      ref_phase   <= 1'b0;
      q_wr        <= 1'b0;
      q_addr      <= '0;
      q_data      <= '0;
      q_be        <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        q_wr   <= req_write;
        q_addr <= req_addr;
        q_data <= req_wdata;
        q_be   <= req_be;
      end
      unique case (st)
        ST_IDLE: begin
          if (have_req) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= mux_bus;
            cnt        <= CNT_W'(T_RCD - 1);
            st         <= ST_ROW_OPEN;
          end else if (go_ref) begin
            dram_cas_n <= '0;
            ref_phase  <= 1'b0;
            cnt        <= CNT_W'(T_CSR - 1);
            if (init_left != '0) init_left <= init_left - 1'b1;
            st         <= ST_REFRESH;
          end else if (accept) begin
            have_req <= 1'b1;
          end
        end
        ST_ROW_OPEN: begin
          if (have_req) begin
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else begin
              dram_addr   <= mux_bus;
              dram_cas_n  <= q_wr ? ~q_be : '0;
              dram_we_n   <= ~q_wr;
              dram_oe_n   <= q_wr;
              dram_dq_oe  <= q_wr;
              dram_dq_out <= q_data;
              cnt         <= CNT_W'(T_CAS - 1);
              st          <= ST_COL_ACCESS;
            end
          end else if (ref_pend) begin
            dram_ras_n <= 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
            st         <= ST_PRECHARGE;
          end else if (accept) begin
            have_req <= 1'b1;
            if (same_row) begin
              cnt <= '0;
            end else begin
              dram_ras_n <= 1'b1;
              cnt        <= CNT_W'(T_RP - 1);
              st         <= ST_PRECHARGE;
            end
          end
        end
        ST_COL_ACCESS: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            dram_cas_n <= '1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            have_req   <= 1'b0;
            if (!q_wr) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
            st <= ST_ROW_OPEN;
          end
        end
        ST_PRECHARGE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           st  <= ST_IDLE;
        end
        ST_REFRESH: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!ref_phase) begin
            dram_ras_n <= 1'b0;
            ref_phase  <= 1'b1;
            cnt        <= CNT_W'(T_RAS_REF - 1);
          end else begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= '1;
            cnt        <= CNT_W'(T_RP - 1);
            st         <= ST_PRECHARGE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Row strobe high-time counter, used only by the precharge property
  logic [CNT_W-1:0] ras_hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                 ras_hi_cnt <= '0;
    else if (!dram_ras_n)       ras_hi_cnt <= '0;
    else if (ras_hi_cnt != '1)  ras_hi_cnt <= ras_hi_cnt + 1'b1;
  end

  p_precharge_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ras_hi_cnt >= CNT_W'(T_RP));

  p_cas_needs_ras_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != '1) && (st != ST_REFRESH) |-> !dram_ras_n);

  p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) && (dram_cas_n == '0) |-> $past(dram_cas_n) == '0);

  p_refresh_blocks_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(dram_cas_n) == '0) && !$past(dram_oe_n));
endmodule

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
  localparam int T_RP   = 3;
  localparam int REF_IV = 300;
  localparam int N_INIT = 8;

  typedef struct {
    bit          wr;
    logic [16:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
  } breq_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [8:0]  dram_addr;
  logic        dram_ras_n;
  logic [1:0]  dram_cas_n;
  logic        dram_we_n;
  logic        dram_oe_n;
  logic [15:0] dram_dq_out;
  logic        dram_dq_oe;
  logic [15:0] dram_dq_in = '0;

  edo_dram_ctrl #(.T_RP(T_RP), .REF_INTERVAL(REF_IV), .INIT_REFRESH(N_INIT)) u_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_errors++;
      $display("FAIL R6 watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      finish_run();
    end
  end

  function automatic logic [15:0] seed_word(input int a);
    return 16'(a * 40503) ^ 16'h5A3C;
  endfunction

  // Scoreboard (request-order reference) and behavioural memory array
  logic [15:0] ref_mem [int];
  logic [15:0] dram_mem [int];
  breq_t       acc_q [$];
  logic [15:0] exp_q [$];

  function automatic logic [15:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
  endfunction
  function automatic logic [15:0] dram_rd(input int a);
    return dram_mem.exists(a) ? dram_mem[a] : seed_word(a);
  endfunction

  // Memory model and per-cycle protocol comparison
  bit         prev_ras = 1'b1;
  logic [1:0] prev_cas = 2'b11;
  int         ras_hi = 0;
  bit         cbr_active = 1'b0;
  int         ref_count = 0;
  int         nonref_falls = 0;
  int         last_ref = -1;
  bit         seen_ready = 1'b0;
  logic [7:0] m_row = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1;
      prev_cas = 2'b11;
      ras_hi   = 0;
    end else begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected response", 32'(rsp_rdata), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R2 read data", 32'(rsp_rdata), 32'(e));
        end
      end
      if (!seen_ready && req_ready) begin
        seen_ready = 1'b1;
        chk(ref_count == N_INIT, "R9 start-up refresh count", 32'(ref_count), 32'(N_INIT));
      end
      if (prev_ras && !dram_ras_n) begin
        chk(ras_hi >= T_RP, "R5 precharge width", 32'(ras_hi), 32'(T_RP));
        if (dram_cas_n == 2'b00) begin
          chk(prev_cas == 2'b00, "R7 column strobes before row", 32'(prev_cas), 0);
          cbr_active = 1'b1;
          ref_count++;
          if (seen_ready && last_ref >= 0)
            chk(cyc - last_ref <= REF_IV + 30, "R7 refresh spacing", 32'(cyc - last_ref), 32'(REF_IV + 30));
          last_ref = cyc;
        end else begin
          nonref_falls++;
          m_row = dram_addr[7:0];
          chk(dram_addr[8] == 1'b0, "R1 row bus bit 8", 32'(dram_addr), 0);
          if (acc_q.size() != 0)
            chk(dram_addr[7:0] == acc_q[0].addr[16:9], "R1 row address", 32'(dram_addr), 32'(acc_q[0].addr[16:9]));
        end
      end
      if (!prev_ras && dram_ras_n) cbr_active = 1'b0;
      ras_hi = dram_ras_n ? ras_hi + 1 : 0;
      if (cbr_active || (dram_ras_n && dram_cas_n != 2'b11))
        chk(!req_ready, "R8 ready during refresh", 32'(req_ready), 0);
      if ((prev_cas & ~dram_cas_n) != 2'b00) begin
        if (dram_ras_n) begin
          chk(dram_cas_n == 2'b00, "R7 both strobes in refresh", 32'(dram_cas_n), 0);
        end else if (!cbr_active) begin
          if (acc_q.size() == 0) chk(1'b0, "R6 column strobe without request", 32'(dram_cas_n), 0);
          else begin
            breq_t a;
            int    idx;
            a = acc_q.pop_front();
            idx = int'({m_row, dram_addr});
            chk(dram_addr == a.addr[8:0], "R1 column address", 32'(dram_addr), 32'(a.addr[8:0]));
            chk(m_row == a.addr[16:9], "R4 access in open row", 32'(m_row), 32'(a.addr[16:9]));
            if (a.wr) begin
              logic [15:0] w;
              chk(dram_cas_n == ~a.be, "R3 lane strobes", 32'(dram_cas_n), 32'(~a.be));
              chk(!dram_we_n && dram_dq_oe && dram_dq_out == a.data, "R3 write drive",
                  32'(dram_dq_out), 32'(a.data));
              w = dram_rd(idx);
              if (!dram_cas_n[0]) w[7:0]  = dram_dq_out[7:0];
              if (!dram_cas_n[1]) w[15:8] = dram_dq_out[15:8];
              dram_mem[idx] = w;
            end else begin
              chk(dram_cas_n == 2'b00 && !dram_oe_n && dram_we_n, "R2 read strobes",
                  32'({dram_cas_n, dram_oe_n, dram_we_n}), 32'(1));
              dram_dq_in = dram_rd(idx);
            end
          end
        end
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
  end

  task automatic send(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    breq_t r;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    while (!req_ready) @(negedge clk);
    r.wr = wr; r.addr = a; r.data = d; r.be = be;
    if (wr) begin
      logic [15:0] w;
      w = ref_rd(int'(a));
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      ref_mem[int'(a)] = w;
      if (be != 2'b00) acc_q.push_back(r);
    end else begin
      exp_q.push_back(ref_rd(int'(a)));
      acc_q.push_back(r);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain;
    while (acc_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int nf0;
    int rf0;
    logic [31:0] s;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && dram_oe_n && !dram_dq_oe,
        "R9 strobes inactive in reset", 32'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 32'h1f);
    chk(!req_ready, "R9 not ready in reset", 32'(req_ready), 0);
    rst_n = 1'b1;
    while (!seen_ready) @(negedge clk);

    // Page hits with every byte-enable pattern, then read back (R3, R4)
    nf0 = nonref_falls; rf0 = ref_count;
    send(1'b1, {8'h21, 9'd4}, 16'hA1B2, 2'b11);
    send(1'b1, {8'h21, 9'd5}, 16'hC3D4, 2'b01);
    send(1'b1, {8'h21, 9'd6}, 16'hE5F6, 2'b10);
    send(1'b1, {8'h21, 9'd7}, 16'h1357, 2'b00);
    for (int i = 4; i < 8; i++) send(1'b0, {8'h21, 9'(i)}, 16'h0, 2'b00);
    drain();
    chk(nonref_falls - nf0 <= 1 + (ref_count - rf0), "R4 page hits without row strobe",
        32'(nonref_falls - nf0), 32'(1 + ref_count - rf0));

    // Alternating rows: each request opens a row (R5)
    nf0 = nonref_falls; rf0 = ref_count;
    for (int i = 0; i < 6; i++) send(1'b0, {8'(i[0] ? 8'h40 : 8'h41), 9'(i)}, 16'h0, 2'b00);
    drain();
    chk(nonref_falls - nf0 == 6, "R5 page miss reopens row", 32'(nonref_falls - nf0), 6);

    // Address extremes (R1)
    send(1'b1, 17'h00000, 16'h0F0F, 2'b11);
    send(1'b1, 17'h1FFFF, 16'hF00D, 2'b11);
    send(1'b1, 17'h001FF, 16'hBEEF, 2'b11);
    send(1'b1, 17'h00200, 16'hCAFE, 2'b11);
    send(1'b0, 17'h00000, 16'h0, 2'b00);
    send(1'b0, 17'h1FFFF, 16'h0, 2'b00);
    send(1'b0, 17'h001FF, 16'h0, 2'b00);
    send(1'b0, 17'h00200, 16'h0, 2'b00);
    drain();

    // Idle long enough for several periodic refreshes (R7)
    rf0 = ref_count;
    repeat (3 * REF_IV + 20) @(negedge clk);
    chk(ref_count - rf0 >= 3, "R7 periodic refresh while idle", 32'(ref_count - rf0), 3);

    // Mixed traffic with refresh interleaving (R2, R3, R6, R8)
    s = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      send(s[0], {6'd0, s[10:9], s[20:12]}, s[31:16], s[22:21]);
    end
    for (int i = 0; i < 16; i++) send(1'b0, {6'd0, i[1:0], 9'(i * 3)}, 16'h0, 2'b00);
    drain();
    chk(acc_q.size() == 0 && exp_q.size() == 0, "R6 every request completed",
        32'(acc_q.size() + exp_q.size()), 0);
    finish_run();
  end
endmodule